// File: doc/BRIEF.md
# MDIO management command controller

This block runs a single Clause 22 management transaction to an external PHY each time software issues a command. Software first places a 16-bit value in the data register when it wants a write. It then writes the command register with four things: a clock threshold, a PHY address, a register address, and either the read-request bit or the write-request bit. The controller shifts the complete frame out on MDC/MDIO. When the frame has finished, it clears the request bit. Software detects completion by polling that bit. On a read, the 16 bits sampled from the PHY land in the upper half of the data register.

The MDC waveform comes from dividing the system clock. Each MDC half-period lasts exactly the programmed threshold number of system clocks. A threshold of 0 acts as 1.

The sequencer has six states:

- `ST_IDLE` moves to `ST_PREAMBLE` once a request bit is set.
- `ST_PREAMBLE` (32 ones) moves to `ST_HEADER` after bit 31.
- `ST_HEADER` (start code, opcode, PHY address, register address) moves to `ST_TURN` after bit 45.
- `ST_TURN` moves to `ST_DATA` after bit 47.
- `ST_DATA` moves to `ST_DONE` after bit 63.
- `ST_DONE` always returns to `ST_IDLE` in the next cycle and clears the request bits.

Each of these bit-boundary transitions happens on the system clock in which MDC falls.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, MDC and MDIO output enable are low, and both the command register (`reg_sel`=0) and the data register (`reg_sel`=1) read back as zero.
- R2: A write command (bit 25 of the command register) sends 64 bits MSB-first, each valid at an MDC rising edge. The bits are: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 bits of data register [15:0]. Output enable is high for all 64 bits, and MDIO does not change while MDC is high.
- R3: A read command (bit 24) sends the same preamble and header with opcode 10, keeping output enable high for the first 46 bits. Output enable is then low for the 2 turnaround bits and the 16 data bits.
- R4: During a read, MDIO is sampled on the 16 MDC rising edges of the data phase, MSB first. The result is placed in data register [31:16], and data register [15:0] is left unchanged.
- R5: The request bit stays set from the command write until the transaction ends, and is then cleared. Polling sees it set for exactly 128·T+2 consecutive clocks after the command write, where T is the effective threshold.
- R6: Command field [7:0] is the threshold. Every MDC half-period lasts T = max(threshold,1) system clocks, and a frame has 128 MDC transitions.
- R7: A command register write while a request bit is set is ignored. The running frame, the duration and the read-back fields (PHY address in [12:8], register address in [20:16], threshold in [7:0]) keep the original command's values.
- R8: If both request bits are set, a read is performed and both bits clear at its end.
- R9: With no request pending, MDC stays low, output enable stays low and no MDC edges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 the data register |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read-back of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High while the block drives MDIO |
| mdio_i | input | 1 | Serial data returned from the PHY |

## Verification
A wrong sequencer state or bit count appears at the ports within one MDC period. It shows up as an out-of-place frame bit, or as output enable releasing on the wrong bit. A divider fault shows up at the next MDC edge as a half-period that differs from the threshold. A stuck or early request clear is visible in the polled command register as a duration that differs from 128·T+2 clocks. A read-capture fault is visible in the data register read straight after the request bit clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int MDIO_REG_W   = 32;
    localparam int MDIO_THR_W   = 8;
    localparam int MDIO_ADDR_W  = 5;
    localparam int MDIO_DATA_W  = 16;
    localparam int MDIO_PRE_W   = 32;

    // command register field positions
    localparam int CMD_THR_LSB  = 0;
    localparam int CMD_PHY_LSB  = 8;
    localparam int CMD_REG_LSB  = 16;
    localparam int CMD_RD_BIT   = 24;
    localparam int CMD_WR_BIT   = 25;

    // data register field positions
    localparam int DAT_WR_LSB   = 0;
    localparam int DAT_RD_LSB   = 16;

    localparam logic SEL_CMD    = 1'b0;
    localparam logic SEL_DATA   = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [THR_W-1:0] thr,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [THR_W-1:0] cnt;
    logic [THR_W-1:0] limit;
    logic             wrap;

    assign limit     = (thr == '0) ? '0 : thr - THR_W'(1);
    assign wrap      = run && (cnt == limit);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + THR_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_sr.sv
module mdio_frame_sr #(
    parameter int FRAME_W = 64,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               shift,
    input  logic               capture,
    input  logic               sdi,
    output logic               sdo,
    output logic [DATA_W-1:0]  rx_word
);
    logic [FRAME_W-1:0] tx_sr;

    assign sdo = tx_sr[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= frame;
        end else if (shift) begin
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (capture) begin
            rx_word <= {rx_word[DATA_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_W   = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic        rise_tick,
    input  logic        fall_tick,
    output mdio_state_e state,
    output logic        busy,
    output logic        run,
    output logic        load,
    output logic        shift,
    output logic        capture,
    output logic        done,
    output logic        oe
);
    localparam int FRAME_W  = PRE_W + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int PRE_END  = PRE_W - 1;
    localparam int HDR_END  = PRE_W + 4 + 2 * ADDR_W - 1;
    localparam int TA_END   = HDR_END + 2;
    localparam int LAST_BIT = FRAME_W - 1;

    mdio_state_e      nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic             at_pre_end, at_hdr_end, at_ta_end, at_last;

    assign at_pre_end = fall_tick && (bit_cnt == CNT_W'(PRE_END));
    assign at_hdr_end = fall_tick && (bit_cnt == CNT_W'(HDR_END));
    assign at_ta_end  = fall_tick && (bit_cnt == CNT_W'(TA_END));
    assign at_last    = fall_tick && (bit_cnt == CNT_W'(LAST_BIT));

    // state register and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
            end else if (fall_tick) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start)      nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (at_pre_end) nxt = ST_HEADER;
            ST_HEADER:   if (at_hdr_end) nxt = ST_TURN;
            ST_TURN:     if (at_ta_end)  nxt = ST_DATA;
            ST_DATA:     if (at_last)    nxt = ST_DONE;
            ST_DONE:                     nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        run     = 1'b0;
        oe      = 1'b0;
        done    = 1'b0;
        load    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_PREAMBLE, ST_HEADER: begin
                run = 1'b1;
                oe  = 1'b1;
            end
            ST_TURN: begin
                run = 1'b1;
                oe  = !is_read;
            end
            ST_DATA: begin
                run     = 1'b1;
                oe      = !is_read;
                capture = is_read && rise_tick;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        shift = run && fall_tick;
    end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int REG_W  = MDIO_REG_W,
    parameter int THR_W  = MDIO_THR_W,
    parameter int ADDR_W = MDIO_ADDR_W,
    parameter int DATA_W = MDIO_DATA_W,
    parameter int PRE_W  = MDIO_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int FRAME_W = PRE_W + 4 + 2 * ADDR_W + 2 + DATA_W;

    logic [THR_W-1:0]  cmd_thr_q;
    logic [ADDR_W-1:0] cmd_phy_q;
    logic [ADDR_W-1:0] cmd_reg_q;
    logic              rd_req_q;
    logic              wr_req_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;

    mdio_state_e       state;
    logic              busy, run, load, shift, capture, done;
    logic              mdc_rise, mdc_fall;
    logic              pending, cmd_accept, is_read;
    logic [DATA_W-1:0] rx_word;
    logic [FRAME_W-1:0] frame;

    assign pending    = rd_req_q || wr_req_q;
    assign cmd_accept = reg_wr_en && (reg_sel == SEL_CMD) && !pending;
    assign is_read    = rd_req_q;

    assign frame = {{PRE_W{1'b1}}, 2'b01,
                    (is_read ? 2'b10 : 2'b01),
                    cmd_phy_q, cmd_reg_q, 2'b10,
                    (is_read ? {DATA_W{1'b0}} : wdat_q)};

    // command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_thr_q <= '0;
            cmd_phy_q <= '0;
            cmd_reg_q <= '0;
            rd_req_q  <= 1'b0;
            wr_req_q  <= 1'b0;
        end else if (cmd_accept) begin
            cmd_thr_q <= reg_wdata[CMD_THR_LSB +: THR_W];
            cmd_phy_q <= reg_wdata[CMD_PHY_LSB +: ADDR_W];
            cmd_reg_q <= reg_wdata[CMD_REG_LSB +: ADDR_W];
            rd_req_q  <= reg_wdata[CMD_RD_BIT];
            wr_req_q  <= reg_wdata[CMD_WR_BIT];
        end else if (done) begin
            rd_req_q  <= 1'b0;
            wr_req_q  <= 1'b0;
        end
    end

    // data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            if (reg_wr_en && (reg_sel == SEL_DATA)) begin
                wdat_q <= reg_wdata[DAT_WR_LSB +: DATA_W];
            end
            if (done && is_read) begin
                rdat_q <= rx_word;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_DATA) begin
            reg_rdata[DAT_WR_LSB +: DATA_W] = wdat_q;
            reg_rdata[DAT_RD_LSB +: DATA_W] = rdat_q;
        end else begin
            reg_rdata[CMD_THR_LSB +: THR_W]  = cmd_thr_q;
            reg_rdata[CMD_PHY_LSB +: ADDR_W] = cmd_phy_q;
            reg_rdata[CMD_REG_LSB +: ADDR_W] = cmd_reg_q;
            reg_rdata[CMD_RD_BIT]            = rd_req_q;
            reg_rdata[CMD_WR_BIT]            = wr_req_q;
        end
    end

    mdio_seq #(
        .PRE_W  (PRE_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pending),
        .is_read   (is_read),
        .rise_tick (mdc_rise),
        .fall_tick (mdc_fall),
        .state     (state),
        .busy      (busy),
        .run       (run),
        .load      (load),
        .shift     (shift),
        .capture   (capture),
        .done      (done),
        .oe        (mdio_oe)
    );

    mdio_clk_div #(
        .THR_W (THR_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .thr       (cmd_thr_q),
        .mdc       (mdc),
        .rise_tick (mdc_rise),
        .fall_tick (mdc_fall)
    );

    mdio_frame_sr #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W)
    ) u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .frame   (frame),
        .shift   (shift),
        .capture (capture),
        .sdi     (mdio_i),
        .sdo     (mdio_o),
        .rx_word (rx_word)
    );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
    parameter int THR_W  = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              rd_req,
    input logic              wr_req,
    input logic [THR_W-1:0]  cmd_thr,
    input logic [ADDR_W-1:0] cmd_phy,
    input logic [ADDR_W-1:0] cmd_reg
);
    logic             mdc_d;
    logic [THR_W:0]   run_len;
    logic [THR_W:0]   thr_eff;

    assign thr_eff = (cmd_thr == '0) ? (THR_W+1)'(1) : {1'b0, cmd_thr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_d   <= 1'b0;
            run_len <= '0;
        end else begin
            mdc_d <= mdc;
            if (!busy) begin
                run_len <= '0;
            end else if (mdc != mdc_d) begin
                run_len <= (THR_W+1)'(1);
            end else begin
                run_len <= run_len + (THR_W+1)'(1);
            end
        end
    end

    p_mdio_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_req || wr_req));

    p_req_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!rd_req && !wr_req));

    p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mdc != mdc_d)) |-> (run_len == thr_eff));

    p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({cmd_thr, cmd_phy, cmd_reg}));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(
    .THR_W  (THR_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .rd_req  (rd_req_q),
    .wr_req  (wr_req_q),
    .cmd_thr (cmd_thr_q),
    .cmd_phy (cmd_phy_q),
    .cmd_reg (cmd_reg_q)
);

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
    typedef struct packed {
        logic        rd;
        logic [7:0]  thr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [15:0] pat;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd2,  5'h01, 5'h00, 16'h1234, 16'h0000},
        '{1'b1, 8'd3,  5'h1F, 5'h02, 16'h5A5A, 16'hA5C3},
        '{1'b0, 8'd1,  5'h15, 5'h1F, 16'h8001, 16'h0000},
        '{1'b1, 8'd2,  5'h00, 5'h11, 16'h0F0F, 16'hFFFE},
        '{1'b0, 8'h34, 5'h0A, 5'h05, 16'hC0DE, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // monitor state
    logic        mdc_prev = 1'b0;
    int          rise_n = 0;
    int          trans = 0;
    int          run_len = 0;
    int          half_bad = 0;
    int          exp_half = 1;
    logic [15:0] cur_pat = '0;
    logic [63:0] act_o = '0;
    logic [63:0] act_oe = '0;

    always #2 clk = ~clk;

    mdio_cmd_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always @(negedge clk) begin
        if (mdc !== mdc_prev) begin
            trans = trans + 1;
            if (trans > 1 && run_len != exp_half) half_bad = half_bad + 1;
            run_len = 1;
        end else begin
            run_len = run_len + 1;
        end
        if (mdc === 1'b1 && mdc_prev === 1'b0) begin
            if (rise_n < 64) begin
                act_o[63 - rise_n]  = mdio_o;
                act_oe[63 - rise_n] = mdio_oe;
            end
            rise_n = rise_n + 1;
            if (rise_n >= 48 && rise_n <= 63) mdio_i = cur_pat[63 - rise_n];
            else mdio_i = 1'b1;
        end
        mdc_prev = mdc;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic rd, input logic wr,
                                            input logic [7:0] thr,
                                            input logic [4:0] phy, input logic [4:0] rg);
        return (32'(wr) << 25) | (32'(rd) << 24) | (32'(rg) << 16) |
               (32'(phy) << 8) | 32'(thr);
    endfunction

    task automatic arm(input int thr, input logic [15:0] pat);
        @(posedge clk);
        #1;
        rise_n   = 0;
        trans    = 0;
        half_bad = 0;
        run_len  = 0;
        exp_half = (thr == 0) ? 1 : thr;
        cur_pat  = pat;
        act_o    = '0;
        act_oe   = '0;
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_sel   = 1'b0;
    endtask

    // counts negedges with a request bit set; optionally injects a command write
    task automatic wait_done(input int inj_at, input logic [31:0] inj_cmd, output int n);
        n = 0;
        while (reg_rdata[25:24] != 2'b00 && n < 100000) begin
            n++;
            if (n == inj_at) begin
                reg_sel = 1'b0; reg_wdata = inj_cmd; reg_wr_en = 1'b1;
            end else begin
                reg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
    endtask

    task automatic check_frame(input logic rd, input int thr, input logic [4:0] phy,
                               input logic [4:0] rg, input logic [15:0] wd, input int n);
        logic [63:0] exp_o, mask;
        int eff;
        eff   = (thr == 0) ? 1 : thr;
        exp_o = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10,
                 (rd ? 16'h0000 : wd)};
        mask  = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
        chk(rise_n == 64, "R6", "rising edge count", 64'(rise_n), 64'd64);
        chk(trans == 128 && half_bad == 0, "R6", "half-period (bad count)",
            64'(half_bad), 64'd0);
        chk(n == 128 * eff + 2, "R5", "request duration", 64'(n), 64'(128 * eff + 2));
        if (rd) begin
            chk((act_o & mask) == (exp_o & mask), "R3", "read header bits",
                act_o & mask, exp_o & mask);
            chk(act_oe == mask, "R3", "read output enable", act_oe, mask);
        end else begin
            chk(act_o == exp_o, "R2", "write frame bits", act_o, exp_o);
            chk(act_oe == mask, "R2", "write output enable", act_oe, mask);
        end
    endtask

    task automatic check_data(input logic [15:0] exp_rd, input logic [15:0] exp_wd);
        @(negedge clk);
        reg_sel = 1'b1;
        #1;
        chk(reg_rdata[31:16] == exp_rd, "R4", "read data field",
            64'(reg_rdata[31:16]), 64'(exp_rd));
        chk(reg_rdata[15:0] == exp_wd, "R4", "write data field",
            64'(reg_rdata[15:0]), 64'(exp_wd));
        reg_sel = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "mdc/oe in reset",
            64'({mdc, mdio_oe}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_sel = 1'b0; #1;
        chk(reg_rdata == 32'h0, "R1", "command reg after reset", 64'(reg_rdata), 64'd0);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 32'h0, "R1", "data reg after reset", 64'(reg_rdata), 64'd0);
        reg_sel = 1'b0;

        // table-driven transactions (R2..R6)
        for (int i = 0; i < NVEC; i++) begin
            reg_write(1'b1, {16'h0, VECS[i].wd});
            arm(int'(VECS[i].thr), VECS[i].pat);
            reg_write(1'b0, mk_cmd(VECS[i].rd, !VECS[i].rd, VECS[i].thr,
                                   VECS[i].phy, VECS[i].rg));
            wait_done(0, 32'h0, n);
            check_frame(VECS[i].rd, int'(VECS[i].thr), VECS[i].phy, VECS[i].rg,
                        VECS[i].wd, n);
            if (VECS[i].rd) check_data(VECS[i].pat, VECS[i].wd);
        end

        // R6: threshold 0 behaves as 1
        reg_write(1'b1, 32'h0000_3C3C);
        arm(0, 16'h0);
        reg_write(1'b0, mk_cmd(1'b0, 1'b1, 8'd0, 5'h07, 5'h09));
        wait_done(0, 32'h0, n);
        check_frame(1'b0, 0, 5'h07, 5'h09, 16'h3C3C, n);

        // R7: command write while busy is ignored
        reg_write(1'b1, 32'h0000_1111);
        arm(2, 16'h6E2D);
        reg_write(1'b0, mk_cmd(1'b1, 1'b0, 8'd2, 5'h03, 5'h04));
        wait_done(20, mk_cmd(1'b0, 1'b1, 8'd5, 5'h1F, 5'h1F), n);
        check_frame(1'b1, 2, 5'h03, 5'h04, 16'h0, n);
        #1;
        chk(reg_rdata[20:0] == mk_cmd(1'b0, 1'b0, 8'd2, 5'h03, 5'h04) >> 0 &&
            reg_rdata[25:24] == 2'b00, "R7", "command fields after ignored write",
            64'(reg_rdata), 64'(mk_cmd(1'b0, 1'b0, 8'd2, 5'h03, 5'h04)));
        check_data(16'h6E2D, 16'h1111);

        // R9: quiet after completion, no new frame from the ignored write
        arm(2, 16'h0);
        repeat (60) @(negedge clk);
        chk(trans == 0 && mdc == 1'b0 && mdio_oe == 1'b0, "R9", "idle MDC transitions",
            64'(trans), 64'd0);

        // R8: both request bits -> read
        reg_write(1'b1, 32'h0000_2222);
        arm(1, 16'h9137);
        reg_write(1'b0, mk_cmd(1'b1, 1'b1, 8'd1, 5'h12, 5'h06));
        wait_done(0, 32'h0, n);
        chk(reg_rdata[25:24] == 2'b00, "R8", "both request bits cleared",
            64'(reg_rdata[25:24]), 64'd0);
        check_frame(1'b1, 1, 5'h12, 5'h06, 16'h0, n);
        check_data(16'h9137, 16'h2222);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule